// File: doc/BRIEF.md
# Split-Ring Index Producer

The block posts buffer-chain head numbers into a ring that lives in shared memory, then makes them visible to the consumer by writing one free-running 16-bit index word. Head numbers arrive on a valid/ready input. Each head is written into the next free ring slot. The slot is the published index plus the number of heads added since the last publish, reduced modulo the queue size. Several heads can be posted as a batch. The consumer sees none of them until a publish request runs.

A publish acts as an ordering fence. It waits until every ring-entry write has been accepted and has reported completion. Only then does it issue a single write of the new index, and it adopts that index once the index write has completed. Memory traffic uses one 32-bit write port with address, data, byte strobes, a ready input and a completion pulse. The index and the ring entries are 16-bit little-endian half-words. The index sits in the upper half of the word at the base address, and the ring array starts four bytes above the base address. The queue size is a power of two between 2 and 32768.

Top module: `ring_idx_producer`

## Requirements
- R1: After reset `pub_idx` equals the `IDX_RESET` parameter, `mem_wr_valid` and `pub_done` are low, and both `head_ready` and `pub_ready` are high.
- R2: The k-th head accepted since the last publish (k counting from 0) is written to slot s = (`pub_idx` + k) mod `QSIZE`. The write goes to byte address `BASE_ADDR` + 4 + 4*(s div 2). An even slot uses strobe 4'b0011 with the head in data bits 15:0. An odd slot uses strobe 4'b1100 with the head in data bits 31:16. No other write address or strobe is ever used for a ring entry.
- R3: `pub_idx` changes only in the cycle where `pub_done` is high. On that change it advances by the number of heads in the batch, modulo 65536, and it wraps from 65535 to 0.
- R4: A publish of a non-empty batch issues an index write to address `BASE_ADDR` with strobe 4'b1100 and the new index in data bits 31:16. That write is made valid only after every ring-entry write has been accepted and has received its `mem_wr_done` pulse.
- R5: While `mem_wr_valid` is high and `mem_wr_ready` is low, the address, data and strobe stay unchanged and valid stays high.
- R6: Once `QSIZE` heads have been added without a publish, `head_ready` stays low. With fewer heads added and no write pending, `head_ready` is high in the idle state.
- R7: A publish accepted with no heads added issues no memory write, leaves `pub_idx` unchanged, and raises `pub_done` in the cycle after acceptance.
- R8: In the cycle after a publish is accepted, and until the cycle after `pub_done`, both `pub_ready` and `head_ready` are low.
- R9: Each non-empty publish produces exactly one index write. `pub_done` is high for one cycle, in the cycle after the index write's `mem_wr_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | A head number is offered |
| head_ready | output | 1 | The block accepts the offered head |
| head_num | input | 16 | Head descriptor number to post |
| pub_valid | input | 1 | Request to publish the current batch |
| pub_ready | output | 1 | A publish request is accepted this cycle |
| pub_done | output | 1 | One-cycle pulse when a publish has finished |
| pub_idx | output | 16 | Index most recently published |
| mem_wr_valid | output | 1 | A memory write is presented |
| mem_wr_ready | input | 1 | Memory accepts the presented write |
| mem_wr_addr | output | AW | Byte address of the written 32-bit word |
| mem_wr_data | output | 32 | Write data |
| mem_wr_strb | output | 4 | Byte enables, bit 0 for bits 7:0 |
| mem_wr_done | input | 1 | Completion pulse, one per accepted write |

## Verification
The assertions assume the memory side sends one `mem_wr_done` pulse per accepted write. Each pulse arrives at least one cycle after its acceptance, completions come back in acceptance order, and no two arrive in the same cycle. The checker tells ring completions from index completions with its own count of ring writes in flight. The bench memory model keeps completions in a first-in first-out list with a latency of one to three cycles and pops at most one per cycle, which stays inside those assumptions. It varies `mem_wr_ready` from a shift-register pattern so that write-hold and fence cases both occur. Heads are held steady with `head_valid` until they are accepted.

// File: rtl/rip_pkg.sv
package rip_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FENCE,
        ST_IDX,
        ST_IDX_WAIT,
        ST_DONE
    } rip_state_e;

    localparam logic [3:0] STRB_LO = 4'b0011;
    localparam logic [3:0] STRB_HI = 4'b1100;

endpackage

// File: rtl/rip_slot_map.sv
module rip_slot_map #(
    parameter int              QSIZE     = 8,
    parameter int              AW        = 32,
    parameter logic [AW-1:0]   BASE_ADDR = 'h1000,
    localparam int             QW        = $clog2(QSIZE)
) (
    input  logic [QW-1:0] slot,
    input  logic [15:0]   value,
    input  logic          is_idx,
    output logic [AW-1:0] addr,
    output logic [31:0]   data,
    output logic [3:0]    strb
);
    import rip_pkg::*;

    logic [AW-1:0] word_off;
    logic          upper;

    generate
        if (QW == 1) begin : g_single_word
            assign word_off = '0;
        end else begin : g_multi_word
            assign word_off = AW'(slot[QW-1:1]);
        end
    endgenerate

    always_comb begin
        upper = is_idx | slot[0];
        if (is_idx) begin
            addr = BASE_ADDR;
        end else begin
            addr = BASE_ADDR + AW'(4) + (word_off << 2);
        end
        strb = upper ? STRB_HI : STRB_LO;
        data = upper ? {value, 16'h0000} : {16'h0000, value};
    end

endmodule

// File: rtl/rip_outstanding.sv
module rip_outstanding #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec) begin
            cnt_d = cnt_q + CW'(1);
        end else if (dec && !inc) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/ring_idx_producer.sv
module ring_idx_producer
    import rip_pkg::*;
#(
    parameter int            QSIZE     = 8,
    parameter int            AW        = 32,
    parameter logic [AW-1:0] BASE_ADDR = 'h1000,
    parameter logic [15:0]   IDX_RESET = 16'h0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          head_valid,
    output logic          head_ready,
    input  logic [15:0]   head_num,
    input  logic          pub_valid,
    output logic          pub_ready,
    output logic          pub_done,
    output logic [15:0]   pub_idx,
    output logic          mem_wr_valid,
    input  logic          mem_wr_ready,
    output logic [AW-1:0] mem_wr_addr,
    output logic [31:0]   mem_wr_data,
    output logic [3:0]    mem_wr_strb,
    input  logic          mem_wr_done
);
    localparam int QW = $clog2(QSIZE);
    localparam int CW = QW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(QSIZE);

    typedef struct packed {
        rip_state_e    state;
        logic [15:0]   idx;
        logic [CW-1:0] added;
        logic          wr_pend;
        logic          wr_is_idx;
        logic [AW-1:0] wr_addr;
        logic [31:0]   wr_data;
        logic [3:0]    wr_strb;
    } regs_t;

    localparam regs_t REGS_RESET = '{
        state:     ST_IDLE,
        idx:       IDX_RESET,
        added:     '0,
        wr_pend:   1'b0,
        wr_is_idx: 1'b0,
        wr_addr:   '0,
        wr_data:   '0,
        wr_strb:   '0
    };

    regs_t r_d, r_q;

    logic [15:0]   sum_idx;
    logic [QW-1:0] slot;
    logic [15:0]   map_value;
    logic          map_is_idx;
    logic [AW-1:0] map_addr;
    logic [31:0]   map_data;
    logic [3:0]    map_strb;
    logic [CW-1:0] ring_out;
    logic          head_acc;
    logic          pub_acc;
    logic          wr_acc;
    logic          fence_clear;
    logic          out_inc;
    logic          out_dec;

    // Next slot and candidate index share one adder
    assign sum_idx    = r_q.idx + 16'(r_q.added);
    assign slot       = sum_idx[QW-1:0];
    assign map_is_idx = (r_q.state == ST_FENCE);
    assign map_value  = map_is_idx ? sum_idx : head_num;

    rip_slot_map #(
        .QSIZE     (QSIZE),
        .AW        (AW),
        .BASE_ADDR (BASE_ADDR)
    ) slot_map_i (
        .slot   (slot),
        .value  (map_value),
        .is_idx (map_is_idx),
        .addr   (map_addr),
        .data   (map_data),
        .strb   (map_strb)
    );

    // Ring-entry writes accepted but not yet completed
    assign out_inc = wr_acc && !r_q.wr_is_idx;
    assign out_dec = mem_wr_done && (r_q.state != ST_IDX_WAIT);

    rip_outstanding #(
        .CW (CW)
    ) outstanding_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (out_inc),
        .dec   (out_dec),
        .count (ring_out)
    );

    always_comb begin
        head_ready  = (r_q.state == ST_IDLE) && !r_q.wr_pend && (r_q.added < FULL_CNT);
        pub_ready   = (r_q.state == ST_IDLE);
        head_acc    = head_valid && head_ready;
        pub_acc     = pub_valid && pub_ready;
        wr_acc      = r_q.wr_pend && mem_wr_ready;
        fence_clear = !r_q.wr_pend && (ring_out == '0);

        r_d = r_q;
        if (wr_acc) begin
            r_d.wr_pend = 1'b0;
        end

        case (r_q.state)
            ST_IDLE: begin
                if (head_acc) begin
                    r_d.wr_pend   = 1'b1;
                    r_d.wr_is_idx = 1'b0;
                    r_d.wr_addr   = map_addr;
                    r_d.wr_data   = map_data;
                    r_d.wr_strb   = map_strb;
                    r_d.added     = r_q.added + CW'(1);
                end
                if (pub_acc) begin
                    if ((r_q.added == '0) && !head_acc) begin
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.state = ST_FENCE;
                    end
                end
            end
            ST_FENCE: begin
                if (fence_clear) begin
                    r_d.wr_pend   = 1'b1;
                    r_d.wr_is_idx = 1'b1;
                    r_d.wr_addr   = map_addr;
                    r_d.wr_data   = map_data;
                    r_d.wr_strb   = map_strb;
                    r_d.state     = ST_IDX;
                end
            end
            ST_IDX: begin
                if (wr_acc) begin
                    r_d.state = ST_IDX_WAIT;
                end
            end
            ST_IDX_WAIT: begin
                if (mem_wr_done) begin
                    r_d.idx   = sum_idx;
                    r_d.added = '0;
                    r_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= REGS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign pub_done     = (r_q.state == ST_DONE);
    assign pub_idx      = r_q.idx;
    assign mem_wr_valid = r_q.wr_pend;
    assign mem_wr_addr  = r_q.wr_addr;
    assign mem_wr_data  = r_q.wr_data;
    assign mem_wr_strb  = r_q.wr_strb;

endmodule

// File: rtl/ring_idx_producer_chk.sv
module ring_idx_producer_chk #(
    parameter int            QSIZE     = 8,
    parameter int            AW        = 32,
    parameter logic [AW-1:0] BASE_ADDR = 'h1000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          head_valid,
    input logic          head_ready,
    input logic          pub_valid,
    input logic          pub_ready,
    input logic          pub_done,
    input logic [15:0]   pub_idx,
    input logic          mem_wr_valid,
    input logic          mem_wr_ready,
    input logic [AW-1:0] mem_wr_addr,
    input logic [31:0]   mem_wr_data,
    input logic [3:0]    mem_wr_strb,
    input logic          mem_wr_done
);
    int unsigned heads_since;
    int unsigned ring_inflight;
    logic        hd_acc;
    logic        pb_acc;
    logic        wr_acc;
    logic        wr_is_idx;

    assign hd_acc    = head_valid && head_ready;
    assign pb_acc    = pub_valid && pub_ready;
    assign wr_acc    = mem_wr_valid && mem_wr_ready;
    assign wr_is_idx = (mem_wr_addr == BASE_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            heads_since   <= 0;
            ring_inflight <= 0;
        end else begin
            if (pub_done) begin
                heads_since <= 0;
            end else if (hd_acc) begin
                heads_since <= heads_since + 1;
            end
            if (wr_acc && !wr_is_idx && !(mem_wr_done && ring_inflight != 0)) begin
                ring_inflight <= ring_inflight + 1;
            end else if (!(wr_acc && !wr_is_idx) && mem_wr_done && ring_inflight != 0) begin
                ring_inflight <= ring_inflight - 1;
            end
        end
    end

    // R5: a stalled write keeps its contents
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data) && $stable(mem_wr_strb)));

    // R4: the index write only appears with no ring write in flight
    a_r4_fence: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && wr_is_idx) |-> (ring_inflight == 0));

    // R6: never more heads than slots in one batch
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        hd_acc |-> (heads_since < QSIZE));

    // R3: published index moves only with the completion pulse
    a_r3_idx_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pub_idx) |-> pub_done);

    // R7: an empty publish finishes next cycle without memory traffic
    a_r7_empty_publish: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_acc && !hd_acc && heads_since == 0) |=> (pub_done && !mem_wr_valid));

    // R8: no new head or publish right after a publish is taken
    a_r8_busy_after_publish: assert property (@(posedge clk) disable iff (!rst_n)
        pb_acc |=> (!pub_ready && !head_ready));

    // R2: every write uses one 16-bit half of an aligned word
    a_r2_half_word: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> ((mem_wr_strb == 4'b0011 || mem_wr_strb == 4'b1100) && mem_wr_addr[1:0] == 2'b00));

    // R9: completion pulse lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pub_done |=> !pub_done);

endmodule

bind ring_idx_producer ring_idx_producer_chk #(
    .QSIZE     (QSIZE),
    .AW        (AW),
    .BASE_ADDR (BASE_ADDR)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .head_valid   (head_valid),
    .head_ready   (head_ready),
    .pub_valid    (pub_valid),
    .pub_ready    (pub_ready),
    .pub_done     (pub_done),
    .pub_idx      (pub_idx),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_strb  (mem_wr_strb),
    .mem_wr_done  (mem_wr_done)
);

// File: tb/ring_idx_producer_tb.sv
module ring_idx_producer_tb_top;
    localparam int          Q    = 8;
    localparam int          AW   = 32;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam logic [15:0] IRST = 16'hFFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        head_valid = 1'b0;
    logic        head_ready;
    logic [15:0] head_num = '0;
    logic        pub_valid = 1'b0;
    logic        pub_ready;
    logic        pub_done;
    logic [15:0] pub_idx;
    logic        mem_wr_valid;
    logic        mem_wr_ready = 1'b0;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic [3:0]  mem_wr_strb;
    logic        mem_wr_done = 1'b0;

    always #5 clk = ~clk;

    ring_idx_producer #(
        .QSIZE     (Q),
        .AW        (AW),
        .BASE_ADDR (BASE),
        .IDX_RESET (IRST)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .head_valid   (head_valid),
        .head_ready   (head_ready),
        .head_num     (head_num),
        .pub_valid    (pub_valid),
        .pub_ready    (pub_ready),
        .pub_done     (pub_done),
        .pub_idx      (pub_idx),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_ready (mem_wr_ready),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .mem_wr_strb  (mem_wr_strb),
        .mem_wr_done  (mem_wr_done)
    );

    int nchk = 0;
    int nfail = 0;
    int mchk = 0;
    int mfail = 0;
    bit finished = 1'b0;

    // memory model state
    logic [15:0] rb [0:Q-1];
    logic [15:0] idxw = '0;
    int          total_wr = 0;
    int          idx_writes = 0;
    int          ring_inflight = 0;
    int          cyc = 0;
    logic [7:0]  lf = 8'h5A;
    int          fdue [0:31];
    bit          fidx [0:31];
    int          fh = 0;
    int          ft = 0;
    bit          hold_v = 1'b0;
    logic [31:0] hold_a, hold_d;
    logic [3:0]  hold_s;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic mchk_t(input bit ok, input string tag, input longint act, input longint exp);
        mchk++;
        if (!ok) begin
            mfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // memory side: ready pattern, acceptance, completions
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            mem_wr_ready = lf[0] | lf[2];
            if (hold_v) begin
                mchk_t(mem_wr_valid && mem_wr_addr == hold_a && mem_wr_data == hold_d
                       && mem_wr_strb == hold_s, "R5 hold", {mem_wr_addr, mem_wr_data}, {hold_a, hold_d});
            end
            hold_v = mem_wr_valid && !mem_wr_ready;
            hold_a = mem_wr_addr;
            hold_d = mem_wr_data;
            hold_s = mem_wr_strb;
            if (mem_wr_valid && mem_wr_ready) begin
                total_wr++;
                if (mem_wr_addr == BASE && mem_wr_strb == 4'b1100) begin
                    idxw = mem_wr_data[31:16];
                    idx_writes++;
                    mchk_t(ring_inflight == 0, "R4 fence", ring_inflight, 0);
                    fidx[ft] = 1'b1;
                end else if (mem_wr_addr >= BASE + 4 && mem_wr_addr < BASE + 4 + 4 * (Q / 2)
                             && mem_wr_addr[1:0] == 2'b00
                             && (mem_wr_strb == 4'b0011 || mem_wr_strb == 4'b1100)) begin
                    int w;
                    w = int'((mem_wr_addr - BASE - 4) >> 2);
                    if (mem_wr_strb == 4'b0011) rb[2 * w] = mem_wr_data[15:0];
                    else rb[2 * w + 1] = mem_wr_data[31:16];
                    ring_inflight++;
                    fidx[ft] = 1'b0;
                end else begin
                    mchk_t(1'b0, "R2 write address", {mem_wr_addr, 28'h0, mem_wr_strb}, BASE);
                    fidx[ft] = 1'b0;
                end
                fdue[ft] = cyc + 1 + ((lf[5:4] == 2'b11) ? 0 : int'(lf[5:4]));
                ft = (ft + 1) % 32;
            end
            mem_wr_done = 1'b0;
            if (fh != ft && fdue[fh] <= cyc) begin
                mem_wr_done = 1'b1;
                if (!fidx[fh]) ring_inflight--;
                fh = (fh + 1) % 32;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", nchk + mchk, nfail + mfail);
            $finish;
        end
    endtask

    task automatic push_head(input logic [15:0] v);
        head_num   = v;
        head_valid = 1'b1;
        while (!head_ready) @(negedge clk);
        @(negedge clk);
        head_valid = 1'b0;
    endtask

    logic [15:0] exp_idx;

    task automatic run_batch(input int n, input int round);
        logic [15:0] hv [0:Q-1];
        int wr0, iw0, waited;
        wr0 = total_wr;
        iw0 = idx_writes;
        for (int i = 0; i < n; i++) begin
            hv[i] = 16'(16'hB000 + round * 64 + n * 8 + i);
            push_head(hv[i]);
        end
        while (mem_wr_valid) @(negedge clk);
        // R6: ready only while a free slot remains
        chk(head_ready == (n < Q), "R6 head_ready after batch", head_ready, (n < Q));
        pub_valid = 1'b1;
        while (!pub_ready) @(negedge clk);
        @(negedge clk);
        pub_valid = 1'b0;
        chk(!pub_ready && !head_ready, "R8 busy after publish", {pub_ready, head_ready}, 0);
        waited = 0;
        while (!pub_done) begin
            @(negedge clk);
            waited++;
        end
        if (n == 0) begin
            chk(waited == 0, "R7 empty publish latency", waited, 0);
            chk(total_wr == wr0, "R7 no memory write", total_wr - wr0, 0);
            chk(pub_idx == exp_idx, "R7 index unchanged", pub_idx, exp_idx);
        end else begin
            chk(idx_writes == iw0 + 1, "R9 one index write", idx_writes - iw0, 1);
            chk(idxw == 16'(exp_idx + n), "R4 index word value", idxw, 16'(exp_idx + n));
            for (int i = 0; i < n; i++) begin
                int s;
                s = int'(16'(exp_idx + i)) % Q;
                chk(rb[s] == hv[i], "R2 slot content", rb[s], hv[i]);
            end
            chk(pub_idx == 16'(exp_idx + n), "R3 published index", pub_idx, 16'(exp_idx + n));
        end
        exp_idx = 16'(exp_idx + n);
        @(negedge clk);
        chk(!pub_done && pub_ready, "R9 done is one pulse", {pub_done, pub_ready}, 1);
    endtask

    initial begin
        for (int i = 0; i < Q; i++) rb[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pub_idx == IRST, "R1 reset index", pub_idx, IRST);
        chk(!mem_wr_valid && !pub_done, "R1 reset outputs", {mem_wr_valid, pub_done}, 0);
        chk(head_ready && pub_ready, "R1 reset ready", {head_ready, pub_ready}, 3);
        exp_idx = IRST;
        for (int round = 0; round < 3; round++) begin
            for (int n = 0; n <= Q; n++) begin
                run_batch(n, round);
            end
        end
        // second pass in reverse size order after the index has wrapped
        for (int n = Q; n >= 0; n--) begin
            run_batch(n, 3);
        end
        while (fh != ft) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule